// File: doc/BRIEF.md
# Selectable-Accuracy 4x4 Multiplier

This block multiplies two unsigned 4-bit operands into an 8-bit product. The sixteen AND terms are reduced by a short tree: one 4:2 compressor handles the four-high column of weight 8, and a second handles the three-high column of weight 16. A single exact adder then merges the leftover rows. A two-bit mode input sets the internal logic of both compressors at run time. One setting gives exact arithmetic. The other two settings use simplified compressors that accept error in exchange for fewer gates and a shorter path. It suits error-tolerant pixel and signal arithmetic, where a small rate of wrong low-order results costs less than the area and power of a fully exact multiplier.

In the exact and type-1 settings, the compressor at weight 8 passes its carry-out into the carry-in of the compressor at weight 16. In the type-2 setting the compressors have no carry-out, so that link is cut. The product goes through one register stage, which can be removed with a parameter. The register has an asynchronous active-low reset.

Top module: `approx_mul4`

## Requirements
- R1: With mode 2'b00 the registered product equals opA*opB for every one of the 256 operand pairs.
- R2: Mode 2'b11 is not a separate variant and gives exactly the same products as mode 2'b00.
- R3: With mode 2'b01 (type-1) each compressor computes sum = (a|b)^(c|d), cout = (a|b)&(c|d) and carry = cin. The weight-8 compressor takes the four terms of that column with cin = 0. The weight-16 compressor takes the three terms of its column, with d = 0 and cin equal to the weight-8 cout. The product is the exact sum of all remaining weighted bits, taken modulo 256.
- R4: With mode 2'b10 (type-2) each compressor computes sum = (a|b)^(c|d) and carry = (a&b)|(c&d)|((a|b)&(c|d)), has no cout, and takes no cin. The column assignment is the same as in R3. The product is the exact sum of the remaining weighted bits, taken modulo 256.
- R5: If either operand is zero, the product is zero in every mode.
- R6: If either operand is one, the product equals the other operand in every mode.
- R7: While rstN is low the product is zero. Otherwise the product shows the operands and mode from the previous rising clock edge.
- R8: In exact mode the compressor chain reproduces the exact 4:2 relations: sum = a^b^c^d^cin, cout = ((a^b)&c)|(a&b), carry = ((a^b^c^d)&cin)|((a^b^c)&d).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 4 | Unsigned multiplicand |
| opB | input | 4 | Unsigned multiplier |
| mode | input | 2 | 00 exact, 01 type-1, 10 type-2, 11 exact |
| product | output | 8 | Registered product |

## Verification
The bench applies all 256 operand pairs in each of the four modes. It compares every product with an arithmetic model built from the stated compressor equations, and compares the two exact modes with true multiplication as well. A design that routes cout into the wrong column, or leaves the carry link active in type-2 mode, shows up as miscompares on operand pairs with several set bits at the middle weights. The zero-operand and unit-operand pairs test whether an approximate compressor wrongly produces a bit from a single input. A mid-run reset checks that the register clears at once, without waiting for a clock edge.

// File: rtl/approx_mul4_pkg.sv
package approx_mul4_pkg;
  typedef enum logic [1:0] {
    MODE_EXACT = 2'b00,
    MODE_TYPE1 = 2'b01,
    MODE_TYPE2 = 2'b10,
    MODE_ALIAS = 2'b11
  } mulMode_e;

  typedef struct packed {
    logic typeOne;
    logic typeTwo;
    logic chainCarry;
  } cmpStrobe_t;
endpackage

// File: rtl/approx_mul4_ctrl.sv
module approx_mul4_ctrl
  import approx_mul4_pkg::*;
(
  input  logic [1:0] mode,
  output cmpStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    unique case (mulMode_e'(mode))
      MODE_TYPE1: begin
        strobe.typeOne    = 1'b1;
        strobe.chainCarry = 1'b1;
      end
      MODE_TYPE2: strobe.typeTwo = 1'b1;
      default:    strobe.chainCarry = 1'b1;
    endcase
  end
endmodule

// File: rtl/approx_cmp42.sv
module approx_cmp42
  import approx_mul4_pkg::*;
(
  input  cmpStrobe_t strobe,
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  input  logic cin,
  output logic sum,
  output logic carry,
  output logic cout
);
  logic orAB, orCD, andAB, andCD;
  logic xAB, xABC, xABCD;

  always_comb begin
    orAB  = a | b;
    orCD  = c | d;
    andAB = a & b;
    andCD = c & d;
    xAB   = a ^ b;
    xABC  = xAB ^ c;
    xABCD = xABC ^ d;
    if (strobe.typeTwo) begin
      sum   = orAB ^ orCD;
      carry = andAB | andCD | (orAB & orCD);
      cout  = 1'b0;
    end else if (strobe.typeOne) begin
      sum   = orAB ^ orCD;
      carry = cin;
      cout  = orAB & orCD;
    end else begin
      sum   = xABCD ^ cin;
      carry = (xABCD & cin) | (xABC & d);
      cout  = (xAB & c) | andAB;
    end
  end
endmodule

// File: rtl/approx_mul4_dp.sv
module approx_mul4_dp
  import approx_mul4_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  cmpStrobe_t          strobe,
  input  logic [OP_W-1:0]     opA,
  input  logic [OP_W-1:0]     opB,
  output logic [2*OP_W-1:0]   result
);
  localparam int PP_N   = OP_W * OP_W;
  localparam int PROD_W = 2 * OP_W;

  logic [PP_N-1:0] pp;   // pp[i*OP_W+j] = opA[j] & opB[i], weight i+j

  for (genvar i = 0; i < OP_W; i++) begin : g_row
    for (genvar j = 0; j < OP_W; j++) begin : g_col
      assign pp[i*OP_W+j] = opA[j] & opB[i];
    end
  end

  logic sum3, carry3, cout3;
  logic sum4, carry4, cout4;
  logic cin4;

  assign cin4 = strobe.chainCarry & cout3;

  approx_cmp42 u_cmpW8 (
    .strobe(strobe),
    .a(pp[0*OP_W+3]), .b(pp[1*OP_W+2]), .c(pp[2*OP_W+1]), .d(pp[3*OP_W+0]),
    .cin(1'b0),
    .sum(sum3), .carry(carry3), .cout(cout3)
  );

  approx_cmp42 u_cmpW16 (
    .strobe(strobe),
    .a(pp[1*OP_W+3]), .b(pp[2*OP_W+2]), .c(pp[3*OP_W+1]), .d(1'b0),
    .cin(cin4),
    .sum(sum4), .carry(carry4), .cout(cout4)
  );

  logic [PROD_W-1:0] rowA, rowB, rowC, rowD;
  logic [PROD_W:0]   total;

  always_comb begin
    rowA = {pp[3*OP_W+3], carry4, sum4, sum3, pp[0*OP_W+2], pp[0*OP_W+1], pp[0*OP_W+0]};
    rowB = {1'b0, 1'b0, cout4, carry3, 1'b0, pp[1*OP_W+1], pp[1*OP_W+0], 1'b0};
    rowC = {1'b0, 1'b0, pp[2*OP_W+3], 1'b0, 1'b0, pp[2*OP_W+0], 1'b0, 1'b0};
    rowD = {1'b0, 1'b0, pp[3*OP_W+2], 5'b0};
    total  = {1'b0, rowA} + {1'b0, rowB} + {1'b0, rowC} + {1'b0, rowD};
    result = total[PROD_W-1:0];
  end
endmodule

// File: rtl/approx_mul4.sv
module approx_mul4
  import approx_mul4_pkg::*;
#(
  parameter int OP_W    = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic [1:0]        mode,
  output logic [2*OP_W-1:0] product
);
  localparam int PROD_W = 2 * OP_W;

  cmpStrobe_t        strobe;
  logic [PROD_W-1:0] rawProduct;

  approx_mul4_ctrl u_ctrl (.mode(mode), .strobe(strobe));

  approx_mul4_dp #(.OP_W(OP_W)) u_dp (
    .strobe(strobe), .opA(opA), .opB(opB), .result(rawProduct)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) product <= '0;
      else       product <= rawProduct;
    end
  end else begin : g_comb
    assign product = rawProduct;
  end
endmodule

// File: rtl/approx_mul4_chk.sv
module approx_mul4_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] opA,
  input logic [3:0] opB,
  input logic [1:0] mode,
  input logic [7:0] product
);
  logic seen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  // R7
  reset_clear_chk: assert property (@(posedge clk) !rstN |-> product == 8'd0);

  // R1
  exact_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(mode) == 2'b00) |-> product == ({4'b0, $past(opA)} * {4'b0, $past(opB)}));

  // R2
  alias_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(mode) == 2'b11) |-> product == ({4'b0, $past(opA)} * {4'b0, $past(opB)}));

  // R5
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen && ($past(opA) == 4'd0 || $past(opB) == 4'd0)) |-> product == 8'd0);

  // R6
  unit_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(opA) == 4'd1) |-> product == {4'b0, $past(opB)});
endmodule

bind approx_mul4 approx_mul4_chk u_chk (
  .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .mode(mode), .product(product)
);

// File: tb/tb_approx_mul4.sv
module tb_approx_mul4;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opA = '0;
  logic [3:0] opB = '0;
  logic [1:0] mode = '0;
  logic [7:0] product;

  int vectors = 0;
  int fails = 0;
  int exactHits [4];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  approx_mul4 dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .mode(mode), .product(product)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (mode=%0d a=%0d b=%0d)", req, act, exp, mode, opA, opB);
    end
  endtask

  // Compressor truth relations, written per requirement; returns {cout, carry, sum}
  function automatic int cmp(input int kind, input int a, input int b, input int c,
                             input int d, input int ci);
    int s, cy, co, oab, ocd;
    oab = (a + b) > 0;
    ocd = (c + d) > 0;
    if (kind == 2) begin                      // R4
      s  = (oab != ocd);
      cy = (a * b) | (c * d) | (oab * ocd);
      co = 0;
    end else if (kind == 1) begin             // R3
      s  = (oab != ocd);
      cy = ci;
      co = oab * ocd;
    end else begin                            // R8
      s  = (a + b + c + d + ci) % 2;
      co = (((a + b) % 2) * c) | (a * b);
      cy = ((((a + b + c + d) % 2) * ci) | (((a + b + c) % 2) * d));
    end
    return s + 2 * cy + 4 * co;
  endfunction

  function automatic int golden(input int m, input int x, input int y);
    int p [4][4];
    int kind, r3, r4, s3, cy3, co3, s4, cy4, co4, total;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        p[i][j] = ((x >> j) & 1) * ((y >> i) & 1);
    kind = (m == 1) ? 1 : (m == 2) ? 2 : 0;
    r3 = cmp(kind, p[0][3], p[1][2], p[2][1], p[3][0], 0);
    s3 = r3 & 1; cy3 = (r3 >> 1) & 1; co3 = (r3 >> 2) & 1;
    r4 = cmp(kind, p[1][3], p[2][2], p[3][1], 0, (kind == 2) ? 0 : co3);
    s4 = r4 & 1; cy4 = (r4 >> 1) & 1; co4 = (r4 >> 2) & 1;
    total = p[0][0] + 2 * (p[0][1] + p[1][0]) + 4 * (p[0][2] + p[1][1] + p[2][0])
          + 8 * s3 + 16 * (s4 + cy3) + 32 * (cy4 + co4 + p[2][3] + p[3][2]) + 64 * p[3][3];
    return total % 256;
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    opA = 4'd15; opB = 4'd15;
    repeat (3) @(negedge clk);
    // R7: product held at zero under reset
    check(product == 8'd0, "R7", product, 0);
    rstN = 1'b1;

    for (int m = 0; m < 4; m++) begin
      exactHits[m] = 0;
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          @(negedge clk);
          mode = m[1:0]; opA = x[3:0]; opB = y[3:0];
          @(negedge clk);
          if (product == 8'(x * y)) exactHits[m]++;
          case (m)
            0: check(product == 8'(x * y), "R1", product, x * y);
            3: check(product == 8'(x * y), "R2", product, x * y);
            1: check(product == 8'(golden(m, x, y)), "R3", product, golden(m, x, y));
            default: check(product == 8'(golden(m, x, y)), "R4", product, golden(m, x, y));
          endcase
          if (m == 0) check(product == 8'(golden(m, x, y)), "R8", product, golden(m, x, y));
          if (x == 0 || y == 0) check(product == 8'd0, "R5", product, 0);
          if (x == 1) check(product == 8'(y), "R6", product, y);
          if (y == 1) check(product == 8'(x), "R6", product, x);
        end
      end
    end

    // R7: one-cycle latency and asynchronous clear
    @(negedge clk);
    mode = 2'b00; opA = 4'd13; opB = 4'd11;
    #1;
    check(product != 8'd143, "R7", product, 0);
    @(negedge clk);
    check(product == 8'd143, "R7", product, 143);
    #(CLK_PERIOD / 4);
    rstN = 1'b0;
    #1;
    check(product == 8'd0, "R7", product, 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int m = 0; m < 4; m++)
      $display("mode %0d: %0d of 256 products exact", m, exactHits[m]);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule